// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a fast counting source into a square-wave bit clock whose rate software picks through a small byte-wide register port. A 16-bit time constant is assembled from two byte writes. A down-counter runs from that value to zero and spends one extra tick reloading. It then toggles the bit clock, so every half-period lasts the time constant plus two source ticks and the full period is twice that. The counting source is either the system clock or the rising edges of an external clock pin, brought into the system clock domain.

Each terminal count produces a one-cycle zero-count pulse. When the zero-count interrupt is enabled, the pulse sets a sticky interrupt line, which a command write clears. A following divider counts rising edges of the bit clock and emits a one-cycle sampling tick every 1, 16, 32 or 64 of them. To pick a time constant for a wanted rate, take f as the source rate after that divider and compute TC = floor((f + rate) / (2·rate)) − 2.

Top module: `baud_gen`

## Requirements
- R1: After reset, bitClk, sampleTick, zeroCount and irq are all 0, and the generator is disabled.
- R2: Writing address 14 with bit 0 set while the generator is disabled loads the time constant at once and drives bitClk to 0. With the system clock as source, the first and every later bitClk level lasts TC+2 clock cycles.
- R3: The time constant is the byte written at address 12 as bits 7:0 and the byte written at address 13 as bits 15:8.
- R4: A time constant written while the generator runs leaves the current half-period unchanged and applies from the next reload.
- R5: While bit 0 of address 14 is clear, bitClk holds its level and no zero-count pulse occurs.
- R6: Bit 1 of address 14 selects the source: 1 counts system clock cycles, 0 counts rising edges of extClk. In the second case a half-period lasts (TC+2) extClk periods.
- R7: zeroCount is high for exactly one cycle per terminal count. With the system clock as source, that cycle is the one just before bitClk toggles.
- R8: When address 15 bit 1 is set, a zero-count pulse sets irq, which stays set until a write of 0x10 to address 0. With address 15 bit 1 clear, irq stays low.
- R9: Bits 7:6 of address 4 select the sampling divider: 00 = 1, 01 = 16, 10 = 32, 11 = 64. sampleTick is a one-cycle pulse every that many rising edges of bitClk.
- R10: A time constant of 0 gives the shortest half-period, 2 source ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 8 | Register write data |
| extClk | input | 1 | External counting source, asynchronous |
| bitClk | output | 1 | Square-wave bit clock |
| sampleTick | output | 1 | One-cycle pulse per divided bit-clock period |
| zeroCount | output | 1 | One-cycle pulse per terminal count |
| irq | output | 1 | Sticky zero-count interrupt |

## Verification
The hardest case to reach from the ports is a time-constant change that lands in the middle of a running half-period. To show the old value finishes and the new one starts only at the reload, the stimulus waits for a bit-clock edge, writes both bytes well before the next reload, and queues the old interval followed by the new ones. The external-source path and the ×64 divider need long, aligned runs. For the external path the first interval after enabling is queued as "don't care" because the synchronizer phase is unknown, and divider gaps are measured between two successive sampling ticks.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef enum logic [1:0] {
    DIV_X1  = 2'b00,
    DIV_X16 = 2'b01,
    DIV_X32 = 2'b10,
    DIV_X64 = 2'b11
  } divSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadNow;
    logic srcTick;
  } bgStrobe_t;

  localparam int MAX_DIV      = 64;
  localparam int ADDR_CMD     = 0;
  localparam int ADDR_MODE    = 4;
  localparam int ADDR_TC_LO   = 12;
  localparam int ADDR_TC_HI   = 13;
  localparam int ADDR_CTL     = 14;
  localparam int ADDR_IE      = 15;
  localparam int CMD_CLR_STAT = 8'h10;

  function automatic int divRatio(divSel_e s);
    case (s)
      DIV_X16: return 16;
      DIV_X32: return 32;
      DIV_X64: return 64;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TC_W        = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              extClk,
  input  logic              zeroPulse,
  output bgStrobe_t         strobes,
  output logic [TC_W-1:0]   tcValue,
  output divSel_e           divSel,
  output logic              irq
);

  logic [DATA_W-1:0]    tcLoQ, tcHiQ;
  logic                 enableQ, srcSysQ, zeroIeQ, irqQ;
  divSel_e              divSelQ;
  logic [SYNC_STAGES:0] extPipe;
  logic                 extRise;
  logic                 wrLo, wrHi, wrCtl, wrMode, wrIe, clrCmd;

  always_comb begin
    wrLo   = regWrEn && (regAddr == ADDR_W'(ADDR_TC_LO));
    wrHi   = regWrEn && (regAddr == ADDR_W'(ADDR_TC_HI));
    wrCtl  = regWrEn && (regAddr == ADDR_W'(ADDR_CTL));
    wrMode = regWrEn && (regAddr == ADDR_W'(ADDR_MODE));
    wrIe   = regWrEn && (regAddr == ADDR_W'(ADDR_IE));
    clrCmd = regWrEn && (regAddr == ADDR_W'(ADDR_CMD)) &&
             (regWrData == DATA_W'(CMD_CLR_STAT));
  end

  assign extRise = extPipe[SYNC_STAGES-1] & ~extPipe[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcLoQ   <= '0;
      tcHiQ   <= '0;
      enableQ <= 1'b0;
      srcSysQ <= 1'b0;
      zeroIeQ <= 1'b0;
      divSelQ <= DIV_X1;
      irqQ    <= 1'b0;
      extPipe <= '0;
    end else begin
      extPipe <= {extPipe[SYNC_STAGES-1:0], extClk};
      if (wrLo) tcLoQ <= regWrData;
      if (wrHi) tcHiQ <= regWrData;
      if (wrCtl) begin
        enableQ <= regWrData[0];
        srcSysQ <= regWrData[1];
      end
      if (wrMode) divSelQ <= divSel_e'(regWrData[7:6]);
      if (wrIe) zeroIeQ <= regWrData[1];
      // a new event wins over a clear in the same cycle
      if (zeroPulse && zeroIeQ) irqQ <= 1'b1;
      else if (clrCmd)          irqQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.loadNow = wrCtl && regWrData[0] && !enableQ;
    strobes.srcTick = enableQ && (srcSysQ || extRise);
  end

  assign tcValue = {tcHiQ, tcLoQ};
  assign divSel  = divSelQ;
  assign irq     = irqQ;

  assert_load_enables_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadNow |=> enableQ);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(zeroPulse && zeroIeQ));

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrCmd && !(zeroPulse && zeroIeQ)) |=> !irqQ);

endmodule

// File: rtl/baud_gen_dp.sv
module baud_gen_dp
  import baud_gen_pkg::*;
#(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  bgStrobe_t       strobes,
  input  logic [TC_W-1:0] tcValue,
  input  divSel_e         divSel,
  output logic            bitClk,
  output logic            zeroPulse,
  output logic            sampleTick
);

  localparam int DIV_W = $clog2(MAX_DIV);

  logic [TC_W-1:0]  cntQ;
  logic             pendQ, bitClkQ, zeroQ, sampleQ;
  logic [DIV_W-1:0] divCntQ, divLast;
  logic             riseNow;

  always_comb divLast = DIV_W'(divRatio(divSel) - 1);

  assign riseNow = strobes.srcTick && !strobes.loadNow && pendQ && !bitClkQ;

  // terminal count, one reload tick, then toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      pendQ   <= 1'b0;
      bitClkQ <= 1'b0;
      zeroQ   <= 1'b0;
    end else begin
      zeroQ <= 1'b0;
      if (strobes.loadNow) begin
        cntQ    <= tcValue;
        pendQ   <= 1'b0;
        bitClkQ <= 1'b0;
      end else if (strobes.srcTick) begin
        if (pendQ) begin
          cntQ    <= tcValue;
          pendQ   <= 1'b0;
          bitClkQ <= ~bitClkQ;
        end else if (cntQ == '0) begin
          pendQ <= 1'b1;
          zeroQ <= 1'b1;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  // sampling divider on rising bit-clock edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCntQ <= '0;
      sampleQ <= 1'b0;
    end else begin
      sampleQ <= 1'b0;
      if (strobes.loadNow) begin
        divCntQ <= '0;
      end else if (riseNow) begin
        if (divCntQ >= divLast) begin
          divCntQ <= '0;
          sampleQ <= 1'b1;
        end else begin
          divCntQ <= divCntQ + 1'b1;
        end
      end
    end
  end

  assign bitClk     = bitClkQ;
  assign zeroPulse  = zeroQ;
  assign sampleTick = sampleQ;

  assert_toggle_after_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((bitClkQ != $past(bitClkQ)) && !$past(strobes.loadNow)) |-> $past(pendQ));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.srcTick && !strobes.loadNow) |=> ($stable(bitClkQ) && $stable(cntQ) && !zeroQ));

  assert_zero_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    zeroQ |=> !zeroQ);

  assert_sample_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    sampleQ |=> !sampleQ);

  assert_load_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadNow |=> ((cntQ == $past(tcValue)) && !bitClkQ && !pendQ));

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              extClk,
  output logic              bitClk,
  output logic              sampleTick,
  output logic              zeroCount,
  output logic              irq
);

  localparam int TC_W = 2 * DATA_W;

  bgStrobe_t       strobes;
  logic [TC_W-1:0] tcValue;
  divSel_e         divSel;
  logic            zeroPulse;

  baud_gen_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .TC_W(TC_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .extClk(extClk), .zeroPulse(zeroPulse),
    .strobes(strobes), .tcValue(tcValue), .divSel(divSel), .irq(irq)
  );

  baud_gen_dp #(.TC_W(TC_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tcValue(tcValue),
    .divSel(divSel), .bitClk(bitClk), .zeroPulse(zeroPulse),
    .sampleTick(sampleTick)
  );

  assign zeroCount = zeroPulse;

endmodule

// File: tb/test_baud_gen.sv
`timescale 1ns/1ps
module test_baud_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       extClk = 1'b0;
  logic       bitClk, sampleTick, zeroCount, irq;

  int total = 0;
  int bad = 0;

  typedef struct {
    int    len;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  bit restartMon = 1'b0;
  bit zeroChk = 1'b1;
  int zeroMiss = 0;
  int sinceLast = 0;
  logic prevBit = 1'b0;
  logic prevZero = 1'b0;

  always #10 clk = ~clk;

  baud_gen i_baud_gen (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .extClk(extClk), .bitClk(bitClk),
    .sampleTick(sampleTick), .zeroCount(zeroCount), .irq(irq)
  );

  // external source: period of 6 system cycles
  initial begin
    forever begin
      repeat (3) @(posedge clk);
      extClk <= ~extClk;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: measures each bitClk level against the scoreboard queue
  always @(negedge clk) begin
    if (rstN) begin
      if (restartMon) begin
        sinceLast  = 0;
        restartMon = 1'b0;
        prevBit    = bitClk;
      end else begin
        sinceLast++;
        if (bitClk !== prevBit) begin
          if (zeroChk && !prevZero) zeroMiss++;
          if (expQ.size() > 0) begin
            expItem_t e;
            e = expQ.pop_front();
            if (e.len >= 0) check(sinceLast == e.len, e.req, "half-period", sinceLast, e.len);
          end
          sinceLast = 0;
          prevBit   = bitClk;
        end
      end
      if (zeroCount && prevZero) zeroMiss++;
      prevZero = zeroCount;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit restart);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    if (restart) restartMon = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic push(input int len, input string req, input int n);
    for (int i = 0; i < n; i++) begin
      expItem_t e;
      e.len = len; e.req = req;
      expQ.push_back(e);
    end
  endtask

  task automatic drain();
    int g = 0;
    while (expQ.size() != 0 && g < 5000) begin
      @(posedge clk);
      g++;
    end
  endtask

  task automatic measureSample(input int expGap, input string req);
    int n = 0;
    while (sampleTick !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (sampleTick !== 1'b1 && n < 2000);
    check(n == expGap, req, "sampleTick gap", n, expGap);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(bitClk == 1'b0, "R1", "bitClk", bitClk, 0);
    check(sampleTick == 1'b0, "R1", "sampleTick", sampleTick, 0);
    check(zeroCount == 1'b0, "R1", "zeroCount", zeroCount, 0);
    check(irq == 1'b0, "R1", "irq", irq, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: TC=3, system source, levels of 5 cycles
    wr(4'd12, 8'd3, 0); wr(4'd13, 8'd0, 0);
    push(5, "R2", 3);
    wr(4'd14, 8'h03, 1);
    drain();

    // R4: TC change mid half-period
    wr(4'd14, 8'h02, 0);
    wr(4'd12, 8'd5, 0);
    push(7, "R4", 1);
    wr(4'd14, 8'h03, 1);
    drain();
    push(7, "R4", 1);
    push(10, "R4", 2);
    wr(4'd12, 8'd8, 0); wr(4'd13, 8'd0, 0);
    drain();

    // R5: disabled generator holds
    begin
      logic held;
      int zc = 0;
      int chg = 0;
      wr(4'd14, 8'h02, 0);
      @(negedge clk);
      held = bitClk;
      repeat (40) begin
        @(negedge clk);
        if (bitClk !== held) chg++;
        if (zeroCount) zc++;
      end
      check(chg == 0, "R5", "bitClk changes while disabled", chg, 0);
      check(zc == 0, "R5", "zero pulses while disabled", zc, 0);
    end

    // R3: byte-split TC 0x0102 -> 260
    wr(4'd12, 8'h02, 0); wr(4'd13, 8'h01, 0);
    push(260, "R3", 2);
    wr(4'd14, 8'h03, 1);
    drain();
    wr(4'd14, 8'h02, 0);

    // R10: TC=0
    wr(4'd12, 8'd0, 0); wr(4'd13, 8'd0, 0);
    push(2, "R10", 4);
    wr(4'd14, 8'h03, 1);
    drain();

    // R9: divider while running with TC=0 (period 4)
    wr(4'd4, 8'h40, 0); measureSample(64, "R9");
    wr(4'd4, 8'h80, 0); measureSample(128, "R9");
    wr(4'd4, 8'hC0, 0); measureSample(256, "R9");
    wr(4'd4, 8'h00, 0); measureSample(4, "R9");
    wr(4'd14, 8'h02, 0);
    check(zeroMiss == 0, "R7", "zero pulse misplacements", zeroMiss, 0);

    // R6: external source, TC=1 -> 3 ext periods = 18 cycles
    zeroChk = 1'b0;
    wr(4'd12, 8'd1, 0);
    push(-1, "R6", 1);
    push(18, "R6", 3);
    wr(4'd14, 8'h01, 1);
    drain();
    wr(4'd14, 8'h00, 0);
    zeroChk = 1'b1;

    // R8: sticky zero-count interrupt
    wr(4'd15, 8'h02, 0);
    wr(4'd12, 8'd2, 0);
    push(4, "R8", 1);
    wr(4'd14, 8'h03, 1);
    drain();
    @(negedge clk);
    check(irq == 1'b1, "R8", "irq after zero count", irq, 1);
    wr(4'd14, 8'h02, 0);
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R8", "irq held", irq, 1);
    wr(4'd0, 8'h10, 0);
    check(irq == 1'b0, "R8", "irq after clear", irq, 0);
    wr(4'd15, 8'h00, 0);
    push(4, "R8", 2);
    wr(4'd14, 8'h03, 1);
    drain();
    @(negedge clk);
    check(irq == 1'b0, "R8", "irq with enable off", irq, 0);
    wr(4'd14, 8'h02, 0);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule